// File: doc/BRIEF.md
# Station Address PROM Signature Checker

This block watches a byte stream read one byte at a time from a station address PROM. After a start pulse it drops the first byte, which only clears the PROM's counter. It looks at the second byte to decide whether to pulse an address-counter enable. It then hunts for a fixed eight-byte signature inside a bounded window of reads. Once the signature is seen, the next six bytes are the 48-bit station address and the two bytes after that are a 16-bit checksum over the address.

The checksum rule works on little-endian 16-bit words. For each word, the running sum is doubled and folded end-around, the word is added, and the result is folded end-around again. A final value of 0xFFFF counts as zero. A wrong checksum does not cancel detection. The address is still reported, and a bad-checksum flag is raised instead of the good one.

The surrounding logic issues the reads. It presents each byte with a one-cycle valid strobe and watches `done`. If the window runs out without a match, `done` rises with `sigFound` low.

Top module: `addr_prom_sig_check`

## Requirements
- R1: Reset or a `startPulse` clears every output: `sigFound`, `done`, `addrValid`, `csumGood`, `csumBad`, `cntEnPulse` go low and `stationAddr` becomes zero. `startPulse` takes priority over a byte offered in the same cycle.
- R2: The first accepted byte after a start is discarded. If the second byte equals 0x08, `cntEnPulse` is high for exactly the one cycle after the edge that accepted it. For any other value it stays low. Neither byte takes part in the search.
- R3: The signature is FF, 00, 55, AA, FF, 00, 55, AA in stream order. `sigFound` rises at the edge that accepts its last byte, and the very next accepted byte is address byte 0.
- R4: When a search byte does not match the expected signature byte, the match position becomes 1 if the byte is FF and 0 otherwise. A partial match interrupted by FF therefore still completes.
- R5: The search accepts at most 39 bytes. A signature whose last byte is search byte 39 is found. If no match has completed by search byte 39, `done` rises at that edge with `sigFound`, `addrValid` and both checksum flags low. Bytes that arrive later change nothing.
- R6: The six bytes after the signature form the address. Address byte i lands in `stationAddr[8i+7:8i]`. `done` and `addrValid` rise together at the edge that accepts the second checksum byte, and not before.
- R7: The checksum is computed over address words {byte1,byte0}, {byte3,byte2} and {byte5,byte4}, starting from 0. For each word: double the sum, subtract 0xFFFF if the result exceeds 0xFFFF, add the word, and subtract 0xFFFF again if the result exceeds 0xFFFF. It is compared with {checksum byte 1, checksum byte 0}. On a match `csumGood` is set. Otherwise `csumBad` is set and the address is still reported.
- R8: A final sum of exactly 0xFFFF is compared as 0x0000.
- R9: A cycle with `byteValid` low consumes nothing: no counter, match position or stored byte changes.
- R10: A `startPulse` in the middle of a run abandons it, and the sequence restarts from the discard byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Begins a new detection run |
| byteValid | input | 1 | The byte on byteIn is consumed this cycle |
| byteIn | input | 8 | Byte read from the PROM |
| cntEnPulse | output | 1 | One-cycle request to enable the PROM address counter |
| sigFound | output | 1 | Signature has been matched |
| done | output | 1 | Run finished (found or window exhausted) |
| addrValid | output | 1 | stationAddr holds a complete address |
| csumGood | output | 1 | Checksum matched |
| csumBad | output | 1 | Checksum mismatched, address still given |
| stationAddr | output | 48 | Captured address, byte 0 in the low bits |

## Verification
Every result is registered at the edge that accepts the deciding byte. `sigFound` follows the last signature byte, and `done`, `addrValid` and the checksum flags follow the second checksum byte or search byte 39. `cntEnPulse` is visible for the single cycle after the second byte. The bench drives bytes on the falling edge and samples on the next falling edge, one half period after the deciding rising edge. It also checks the value one cycle later where a result must be a one-cycle pulse or must hold. Before the final byte it checks that `done` is still low, so an early result is caught as well as a late one.

// File: rtl/prom_sig_pkg.sv
package prom_sig_pkg;

  localparam int IDX_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DISCARD,
    ST_PEEK,
    ST_SEARCH,
    ST_ADDR,
    ST_CSUM,
    ST_FIN
  } seqState_t;

  typedef struct packed {
    logic             clearAll;
    logic             addrLoad;
    logic [IDX_W-1:0] addrIdx;
    logic             csLoLoad;
    logic             csHiLoad;
  } dpStrobe_t;

  // One word step of the end-around sum, 17-bit intermediates expose the carry.
  function automatic logic [15:0] foldStep(input logic [15:0] acc, input logic [15:0] word);
    logic [16:0] t;
    t = {acc, 1'b0};
    if (t > 17'h0FFFF) t = t - 17'h0FFFF;
    t = t + {1'b0, word};
    if (t > 17'h0FFFF) t = t - 17'h0FFFF;
    return t[15:0];
  endfunction

endpackage

// File: rtl/prom_sig_ctrl.sv
module prom_sig_ctrl
  import prom_sig_pkg::*;
#(
  parameter int                  SIG_LEN      = 8,
  parameter logic [SIG_LEN*8-1:0] SIG_PATTERN = 64'hAA55_00FF_AA55_00FF,
  parameter int                  PROBE_LEN    = 32,
  parameter int                  ADDR_BYTES   = 6,
  parameter logic [7:0]          TRIGGER_BYTE = 8'h08
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  output dpStrobe_t  strobe,
  output logic       cntEnPulse,
  output logic       sigFound,
  output logic       done,
  output logic       addrValid
);

  localparam int WINDOW = PROBE_LEN + SIG_LEN - 1;
  localparam int WIN_W  = $clog2(WINDOW + 1);
  localparam int MI_W   = $clog2(SIG_LEN);
  localparam int NI_W   = MI_W + 1;
  localparam int CNT_W  = $clog2(ADDR_BYTES + 1);

  logic [7:0] sigTab [SIG_LEN];

  generate
    for (genvar k = 0; k < SIG_LEN; k++) begin : g_sig
      assign sigTab[k] = SIG_PATTERN[8*k +: 8];
    end
  endgenerate

  seqState_t        state;
  logic [MI_W-1:0]  matchIdx;
  logic [WIN_W-1:0] winCnt;
  logic [CNT_W-1:0] byteCnt;
  logic [NI_W-1:0]  nextIdx;
  logic             take;
  logic             sigComplete;
  logic             windowLast;

  assign take = byteValid && !startPulse;

  always_comb begin
    if (byteIn == sigTab[matchIdx])      nextIdx = NI_W'(matchIdx) + NI_W'(1);
    else if (byteIn == sigTab[0])        nextIdx = NI_W'(1);
    else                                 nextIdx = '0;
  end

  assign sigComplete = (nextIdx == NI_W'(SIG_LEN));
  assign windowLast  = (winCnt == WIN_W'(WINDOW - 1));

  always_comb begin
    strobe          = '0;
    strobe.clearAll = startPulse;
    strobe.addrIdx  = IDX_W'(byteCnt);
    strobe.addrLoad = take && (state == ST_ADDR);
    strobe.csLoLoad = take && (state == ST_CSUM) && (byteCnt == CNT_W'(0));
    strobe.csHiLoad = take && (state == ST_CSUM) && (byteCnt == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      matchIdx   <= '0;
      winCnt     <= '0;
      byteCnt    <= '0;
      cntEnPulse <= 1'b0;
      sigFound   <= 1'b0;
      done       <= 1'b0;
      addrValid  <= 1'b0;
    end else begin
      cntEnPulse <= 1'b0;
      if (startPulse) begin
        state     <= ST_DISCARD;
        matchIdx  <= '0;
        winCnt    <= '0;
        byteCnt   <= '0;
        sigFound  <= 1'b0;
        done      <= 1'b0;
        addrValid <= 1'b0;
      end else if (byteValid) begin
        case (state)
          ST_DISCARD: state <= ST_PEEK;
          ST_PEEK: begin
            cntEnPulse <= (byteIn == TRIGGER_BYTE);
            state      <= ST_SEARCH;
          end
          ST_SEARCH: begin
            winCnt <= winCnt + WIN_W'(1);
            if (sigComplete) begin
              sigFound <= 1'b1;
              matchIdx <= '0;
              byteCnt  <= '0;
              state    <= ST_ADDR;
            end else if (windowLast) begin
              done  <= 1'b1;
              state <= ST_FIN;
            end else begin
              matchIdx <= MI_W'(nextIdx);
            end
          end
          ST_ADDR: begin
            if (byteCnt == CNT_W'(ADDR_BYTES - 1)) begin
              byteCnt <= '0;
              state   <= ST_CSUM;
            end else begin
              byteCnt <= byteCnt + CNT_W'(1);
            end
          end
          ST_CSUM: begin
            if (byteCnt == CNT_W'(1)) begin
              done      <= 1'b1;
              addrValid <= 1'b1;
              state     <= ST_FIN;
            end else begin
              byteCnt <= CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/prom_sig_dp.sv
module prom_sig_dp
  import prom_sig_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobe,
  input  logic [7:0]              byteIn,
  output logic [ADDR_BYTES*8-1:0] stationAddr,
  output logic                    csumGood,
  output logic                    csumBad
);

  logic [15:0] runSum;
  logic [7:0]  loHold;
  logic [7:0]  csLo;
  logic [15:0] finalSum;
  logic        sumMatch;

  generate
    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_addr
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                                  stationAddr[8*b +: 8] <= '0;
        else if (strobe.clearAll)                                   stationAddr[8*b +: 8] <= '0;
        else if (strobe.addrLoad && strobe.addrIdx == IDX_W'(b))    stationAddr[8*b +: 8] <= byteIn;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runSum <= '0;
      loHold <= '0;
      csLo   <= '0;
    end else if (strobe.clearAll) begin
      runSum <= '0;
      loHold <= '0;
      csLo   <= '0;
    end else begin
      if (strobe.addrLoad) begin
        if (!strobe.addrIdx[0]) loHold <= byteIn;
        else                    runSum <= foldStep(runSum, {byteIn, loHold});
      end
      if (strobe.csLoLoad) csLo <= byteIn;
    end
  end

  assign finalSum = (runSum == 16'hFFFF) ? 16'h0000 : runSum;
  assign sumMatch = (finalSum == {byteIn, csLo});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csumGood <= 1'b0;
      csumBad  <= 1'b0;
    end else if (strobe.clearAll) begin
      csumGood <= 1'b0;
      csumBad  <= 1'b0;
    end else if (strobe.csHiLoad) begin
      csumGood <= sumMatch;
      csumBad  <= !sumMatch;
    end
  end

endmodule

// File: rtl/addr_prom_sig_check.sv
module addr_prom_sig_check
  import prom_sig_pkg::*;
#(
  parameter int                   SIG_LEN      = 8,
  parameter logic [SIG_LEN*8-1:0] SIG_PATTERN  = 64'hAA55_00FF_AA55_00FF,
  parameter int                   PROBE_LEN    = 32,
  parameter int                   ADDR_BYTES   = 6,
  parameter logic [7:0]           TRIGGER_BYTE = 8'h08
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startPulse,
  input  logic                    byteValid,
  input  logic [7:0]              byteIn,
  output logic                    cntEnPulse,
  output logic                    sigFound,
  output logic                    done,
  output logic                    addrValid,
  output logic                    csumGood,
  output logic                    csumBad,
  output logic [ADDR_BYTES*8-1:0] stationAddr
);

  dpStrobe_t strobe;

  prom_sig_ctrl #(
    .SIG_LEN(SIG_LEN), .SIG_PATTERN(SIG_PATTERN), .PROBE_LEN(PROBE_LEN),
    .ADDR_BYTES(ADDR_BYTES), .TRIGGER_BYTE(TRIGGER_BYTE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .byteValid(byteValid),
    .byteIn(byteIn), .strobe(strobe), .cntEnPulse(cntEnPulse),
    .sigFound(sigFound), .done(done), .addrValid(addrValid)
  );

  prom_sig_dp #(.ADDR_BYTES(ADDR_BYTES)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteIn(byteIn),
    .stationAddr(stationAddr), .csumGood(csumGood), .csumBad(csumBad)
  );

endmodule

// File: rtl/prom_sig_chk.sv
module prom_sig_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              byteValid,
  input logic              cntEnPulse,
  input logic              sigFound,
  input logic              done,
  input logic              addrValid,
  input logic              csumGood,
  input logic              csumBad,
  input logic [ADDR_W-1:0] stationAddr
);

  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (!done && !sigFound && !addrValid && !csumGood && !csumBad && stationAddr == '0));

  assert_cnt_en_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    cntEnPulse |=> !cntEnPulse);

  assert_miss_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !sigFound) |-> (!addrValid && !csumGood && !csumBad && stationAddr == '0));

  assert_addr_with_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> (done && sigFound));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && sigFound) |-> (csumGood != csumBad));

  assert_flags_wait_R7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (!csumGood && !csumBad));

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!byteValid && !startPulse) |=> ($stable(stationAddr) && $stable(done) && $stable(sigFound)));

endmodule

bind addr_prom_sig_check prom_sig_chk #(.ADDR_W(ADDR_BYTES*8)) u_prom_sig_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .byteValid(byteValid),
  .cntEnPulse(cntEnPulse), .sigFound(sigFound), .done(done), .addrValid(addrValid),
  .csumGood(csumGood), .csumBad(csumBad), .stationAddr(stationAddr)
);

// File: tb/test_addr_prom_sig_check.sv
module test_addr_prom_sig_check;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteIn = '0;
  logic        cntEnPulse, sigFound, done, addrValid, csumGood, csumBad;
  logic [47:0] stationAddr;

  int vecCnt = 0;
  int errCnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_prom_sig_check i_addr_prom_sig_check (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .byteValid(byteValid),
    .byteIn(byteIn), .cntEnPulse(cntEnPulse), .sigFound(sigFound), .done(done),
    .addrValid(addrValid), .csumGood(csumGood), .csumBad(csumBad),
    .stationAddr(stationAddr)
  );

  task automatic checkVal(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected checksum from the rule in R7 and R8.
  function automatic logic [15:0] modelSum(input logic [47:0] a);
    int s = 0;
    for (int w = 0; w < 3; w++) begin
      s = s << 1;
      if (s > 32'hFFFF) s = s - 32'hFFFF;
      s = s + int'(a[16*w +: 16]);
      if (s > 32'hFFFF) s = s - 32'hFFFF;
    end
    if (s == 32'hFFFF) s = 0;
    return s[15:0];
  endfunction

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    byteIn = b;
    byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic startRun();
    @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic sendSig();
    sendByte(8'hFF); sendByte(8'h00); sendByte(8'h55); sendByte(8'hAA);
    sendByte(8'hFF); sendByte(8'h00); sendByte(8'h55); sendByte(8'hAA);
  endtask

  task automatic sendAddrCsum(input logic [47:0] a, input logic [15:0] cs);
    for (int i = 0; i < 6; i++) sendByte(a[8*i +: 8]);
    sendByte(cs[7:0]);
    checkVal("R6", "done before last checksum byte", done, 0);
    sendByte(cs[15:8]);
  endtask

  task automatic testReset();
    checkVal("R1", "reset done", done, 0);
    checkVal("R1", "reset sigFound", sigFound, 0);
    checkVal("R1", "reset addr", stationAddr, 48'h0);
    checkVal("R1", "reset flags", {addrValid, csumGood, csumBad, cntEnPulse}, 0);
  endtask

  task automatic testGoodRun();
    logic [47:0] a = 48'h5634_122B_0008;
    startRun();
    sendByte(8'h3C);
    sendByte(8'h08);
    checkVal("R2", "cntEnPulse after 0x08", cntEnPulse, 1);
    idle(1);
    checkVal("R2", "cntEnPulse one cycle", cntEnPulse, 0);
    sendByte(8'h11); sendByte(8'h22); sendByte(8'h33);
    sendSig();
    checkVal("R3", "sigFound at last sig byte", sigFound, 1);
    checkVal("R3", "done still low", done, 0);
    sendAddrCsum(a, modelSum(a));
    checkVal("R6", "done", done, 1);
    checkVal("R6", "addrValid", addrValid, 1);
    checkVal("R6", "address", stationAddr, a);
    checkVal("R7", "csumGood", csumGood, 1);
    checkVal("R7", "csumBad", csumBad, 0);
  endtask

  task automatic testBadCsum();
    logic [47:0] a = 48'hA1B2_C3D4_E5F6;
    startRun();
    checkVal("R1", "start clears done", done, 0);
    checkVal("R1", "start clears addr", stationAddr, 48'h0);
    sendByte(8'h08);
    sendByte(8'h07);
    checkVal("R2", "no cntEnPulse for 0x07", cntEnPulse, 0);
    sendSig();
    sendAddrCsum(a, modelSum(a) ^ 16'h0100);
    checkVal("R7", "address reported on bad sum", stationAddr, a);
    checkVal("R7", "csumBad", csumBad, 1);
    checkVal("R7", "csumGood low", csumGood, 0);
    checkVal("R7", "sigFound kept", sigFound, 1);
  endtask

  task automatic testRestartRule();
    logic [47:0] a = 48'h0102_0304_0506;
    startRun();
    sendByte(8'h00); sendByte(8'h00);
    sendByte(8'hFF); sendByte(8'h00); sendByte(8'h55);
    sendByte(8'hFF); sendByte(8'h00); sendByte(8'h55); sendByte(8'hAA);
    sendByte(8'hFF); sendByte(8'h00); sendByte(8'h55);
    checkVal("R4", "not yet found", sigFound, 0);
    sendByte(8'hAA);
    checkVal("R4", "found after FF restart", sigFound, 1);
    sendAddrCsum(a, modelSum(a));
    checkVal("R4", "address after restart", stationAddr, a);
  endtask

  task automatic testWindowEdge();
    logic [47:0] a = 48'hDEAD_BEEF_0042;
    startRun();
    sendByte(8'h00); sendByte(8'h00);
    for (int i = 0; i < 31; i++) sendByte(8'h5A);
    sendSig();
    checkVal("R5", "found at search byte 39", sigFound, 1);
    checkVal("R5", "done low at 39 when found", done, 0);
    sendAddrCsum(a, modelSum(a));
    checkVal("R5", "csumGood at window edge", csumGood, 1);

    startRun();
    sendByte(8'h00); sendByte(8'h00);
    for (int i = 0; i < 32; i++) sendByte(8'h5A);
    sendByte(8'hFF); sendByte(8'h00); sendByte(8'h55); sendByte(8'hAA);
    sendByte(8'hFF); sendByte(8'h00);
    checkVal("R5", "done low at byte 38", done, 0);
    sendByte(8'h55);
    checkVal("R5", "done at byte 39", done, 1);
    checkVal("R5", "not found", sigFound, 0);
    sendByte(8'hAA);
    for (int i = 0; i < 8; i++) sendByte(8'h77);
    checkVal("R5", "later bytes ignored, addr", stationAddr, 48'h0);
    checkVal("R5", "later bytes ignored, flags", {sigFound, addrValid, csumGood, csumBad}, 0);
    checkVal("R5", "done held", done, 1);
  endtask

  task automatic testFoldZero();
    logic [47:0] a = 48'hFFFF_0000_0000;
    checkVal("R8", "model sum folds to zero", modelSum(a), 48'h0);
    startRun();
    sendByte(8'h00); sendByte(8'h00);
    sendSig();
    sendAddrCsum(a, 16'h0000);
    checkVal("R8", "0xFFFF compared as zero", csumGood, 1);
    startRun();
    sendByte(8'h00); sendByte(8'h00);
    sendSig();
    sendAddrCsum(a, 16'hFFFF);
    checkVal("R8", "raw 0xFFFF rejected", csumBad, 1);
  endtask

  task automatic testGapsAndAbort();
    logic [47:0] a = 48'h9988_7766_5544;
    startRun();
    sendByte(8'h00); sendByte(8'h08);
    sendSig();
    sendByte(8'hC1); sendByte(8'hC2); sendByte(8'hC3);
    startRun();
    checkVal("R10", "abort clears sigFound", sigFound, 0);
    checkVal("R10", "abort clears addr", stationAddr, 48'h0);
    sendByte(8'h00);
    sendByte(8'h08);
    checkVal("R10", "restart reaches peek byte", cntEnPulse, 1);
    sendSig();
    for (int i = 0; i < 6; i++) begin
      sendByte(a[8*i +: 8]);
      idle(3);
    end
    checkVal("R9", "gaps consume nothing, addr", stationAddr, a);
    checkVal("R9", "gaps consume nothing, done", done, 0);
    sendByte(modelSum(a) >> 0);
    idle(2);
    sendByte(modelSum(a) >> 8);
    checkVal("R9", "done after gapped run", done, 1);
    checkVal("R9", "csumGood after gapped run", csumGood, 1);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errCnt++;
    $display("FAIL watchdog: actual hung expected finish");
    finish();
  end

  initial begin
    idle(3);
    testReset();
    rstN = 1'b1;
    idle(2);
    testReset();
    testGoodRun();
    testBadCsum();
    testRestartRule();
    testWindowEdge();
    testFoldZero();
    testGapsAndAbort();
    idle(2);
    finish();
  end

endmodule